// File: doc/BRIEF.md
# Software-Paced I2C Target

This block is an I2C target that answers to one programmable 7-bit address and leaves every protocol decision to software. The SCL and SDA inputs are resynchronised and glitch-filtered. Start and stop conditions are found from SDA changes while SCL is high. Each bus milestone is reported as an event: a bus-command event when the address matches or when a stop ends a transaction this target took part in, and a byte event for each byte received or sent.

Software answers each event with one 16-bit command word. The word clears the pending events and carries the byte to transmit, the ACK/NACK choice for the next received byte, an interrupt mask and the stall enable. When stall is enabled, the target holds SCL low after each event until software clears it. The bus then runs at the pace of the software. A matching address is always acknowledged. An own address of zero turns address matching off.

Top module: `i2c_stall_target`

## Requirements
- R1: After reset, no event or status flag is set, `rx_byte` is zero, `irq` is low, and neither SCL nor SDA is driven.
- R2: An address byte whose upper seven bits equal `own_addr[7:1]` sets `evt_cmd` with `stat_stop`=0 and `stat_rw` equal to the byte's bit 0 (1 = master reads). The target pulls SDA low during the acknowledge clock.
- R3: An address byte that does not match raises no event and leaves SDA released during the acknowledge clock.
- R4: While `own_addr[7:1]` is zero, no address byte matches, including the byte 0x00.
- R5: In a master write, each received byte (MSB first) appears on `rx_byte` with `evt_data` set and `stat_rw`=0. The target ACKs that byte if the ack-enable bit (`cmd_word[3]`) of the most recent command is 1 and NACKs it if the bit is 0.
- R6: In a master read, the target sends `cmd_word[15:8]` of the most recent command, MSB first. After each byte, `evt_data` is set with `stat_rw`=1 and `stat_ack`=1 if the master acknowledged the byte, 0 if not.
- R7: A stop condition after the target was addressed sets `evt_cmd` with `stat_stop`=1. A stop condition in a transaction that did not address the target raises no event.
- R8: With stall enabled (`cmd_word[0]`=1), SCL is held low after each byte or address event until a command clears the event. With stall disabled, SCL is never driven.
- R9: `irq` is high whenever an event is pending and the mask bit (`cmd_word[4]`) of the most recent command is 0. It stays low while the mask bit is 1.
- R10: A command with `cmd_word[6]`=1 clears both event flags.
- R11: A pulse on SDA shorter than the filter length (FILT_LEN clock cycles), while SCL is high, is taken as neither a start nor a stop and does not change the byte being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line as seen on the pad |
| sda_i | input | 1 | SDA line as seen on the pad |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 8 | Own address in bits 7:1; bit 0 unused |
| cmd_we | input | 1 | One-cycle strobe: accept `cmd_word` |
| cmd_word | input | 16 | [15:8] transmit byte, [6] event clear, [4] irq mask, [3] ack enable, [0] stall enable |
| evt_cmd | output | 1 | Bus-command event pending (address match or stop) |
| evt_data | output | 1 | Byte event pending |
| stat_stop | output | 1 | Last command event was a stop |
| stat_rw | output | 1 | 1 when the current transfer is a master read |
| stat_ack | output | 1 | Master acknowledged the last transmitted byte |
| rx_byte | output | 8 | Last byte received from the master |
| irq | output | 1 | Pending event, not masked |

## Verification
A behavioural bus master drives four kinds of transaction: a matching write with both ACK and NACK answers, a non-matching address, addressing with the own address set to zero, and a stalled matching read that ends with a master NACK. These patterns separate address decode from data handling and the ACK path from the NACK path. They also separate stretched operation from free-running operation: in the write, the master never waits, and in the read, it must wait for software at every byte. A one-cycle SDA glitch injected inside a data byte shows whether the filter keeps a false start or stop from resetting the receiver. On every clock, the bench also checks that SCL is pulled only while its model of the pending events and of the stall setting allows it.

// File: rtl/i2ct_pkg.sv
// Package: shared state encoding and command-word bit positions for the
// software-paced I2C target. Assumes nothing beyond IEEE 1800-2017.
package i2ct_pkg;

    // Command word bit positions (software contract)
    localparam int CMD_CLR   = 6;
    localparam int CMD_MASK  = 4;
    localparam int CMD_ACK   = 3;
    localparam int CMD_STALL = 0;

    typedef enum logic [3:0] {
        ST_IDLE,   // no transaction seen
        ST_ADDR,   // shifting in the address byte
        ST_AACK,   // driving ACK for a matched address
        ST_RX,     // shifting in a data byte
        ST_RACK,   // acknowledge slot of a received byte
        ST_TX,     // shifting out a data byte
        ST_TACK,   // master acknowledge slot of a sent byte
        ST_LOAD,   // waiting to load the next transmit byte
        ST_SKIP    // not for us, wait for start or stop
    } tgt_state_t;

endpackage

// File: rtl/i2ct_filter.sv
// Line conditioner: two-flop synchroniser plus a stability filter on SCL and
// SDA, then edge and bus-condition detection on the filtered pair.
// Assumes both lines idle high; a level must persist FILT_LEN cycles to pass.
module i2ct_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0] raw;
    logic [1:0] s1, s2, flt, flt_q;
    logic [CW-1:0] cnt [2];

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        // Synchronise one line and pass a new level only after it is stable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1[g]  <= 1'b1;
                s2[g]  <= 1'b1;
                flt[g] <= 1'b1;
                cnt[g] <= '0;
            end else begin
                s1[g] <= raw[g];
                s2[g] <= s1[g];
                if (s2[g] == flt[g]) begin
                    cnt[g] <= '0;
                end else if (cnt[g] == CW'(FILT_LEN - 1)) begin
                    flt[g] <= s2[g];
                    cnt[g] <= '0;
                end else begin
                    cnt[g] <= cnt[g] + CW'(1);
                end
            end
        end
    end

    // Remember the previous filtered levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= 2'b11;
        else        flt_q <= flt;
    end

    assign scl_f     = flt[0];
    assign sda_f     = flt[1];
    assign scl_rise  = flt[0] & ~flt_q[0];
    assign scl_fall  = ~flt[0] & flt_q[0];
    assign start_det = flt[0] & flt_q[0] & flt_q[1] & ~flt[1];
    assign stop_det  = flt[0] & flt_q[0] & ~flt_q[1] & flt[1];

    // R11: filtered SDA only moves after the synchronised input agreed for FILT_LEN cycles
    a_r11_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt[1]) |-> ($past(s2[1], 1) == flt[1]) && ($past(s2[1], 2) == flt[1]));

endmodule

// File: rtl/i2ct_cmd.sv
// Command register: captures the software command word that answers each
// event. Assumes cmd_we is a single-cycle strobe in the clk domain.
module i2ct_cmd
    import i2ct_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [15:0] cmd_word,
    output logic        stall_en,
    output logic        ack_en,
    output logic        irq_mask,
    output logic [7:0]  tx_hold,
    output logic        evt_clr
);
    // Hold the settings of the most recent command word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_en <= 1'b0;
            ack_en   <= 1'b0;
            irq_mask <= 1'b0;
            tx_hold  <= 8'h00;
        end else if (cmd_we) begin
            stall_en <= cmd_word[CMD_STALL];
            ack_en   <= cmd_word[CMD_ACK];
            irq_mask <= cmd_word[CMD_MASK];
            tx_hold  <= cmd_word[15:8];
        end
    end

    assign evt_clr = cmd_we & cmd_word[CMD_CLR];

endmodule

// File: rtl/i2ct_fsm.sv
// Target engine: address decode, byte shifting, event and status flags,
// SDA drive and the SCL stall. Assumes filtered, synchronous bus inputs
// and that events are raised only while SCL is low (stop excepted).
module i2ct_fsm
    import i2ct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] own_addr,
    input  logic       stall_en,
    input  logic       ack_en,
    input  logic [7:0] tx_hold,
    input  logic       evt_clr,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       evt_cmd,
    output logic       evt_data,
    output logic       stat_stop,
    output logic       stat_rw,
    output logic       stat_ack,
    output logic [7:0] rx_byte
);
    tgt_state_t state;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       sda_drv, active, hold_q, pending, addr_hit, stall_want;

    assign pending    = evt_cmd | evt_data;
    assign addr_hit   = (shreg[7:1] == own_addr[7:1]) && (own_addr[7:1] != 7'd0);
    assign stall_want = stall_en & pending & (state != ST_IDLE);

    // Sequence the transaction and raise events on bus milestones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= 4'd0;
            shreg     <= 8'h00;
            sda_drv   <= 1'b0;
            active    <= 1'b0;
            evt_cmd   <= 1'b0;
            evt_data  <= 1'b0;
            stat_stop <= 1'b0;
            stat_rw   <= 1'b0;
            stat_ack  <= 1'b0;
            rx_byte   <= 8'h00;
        end else begin
            if (evt_clr) begin
                evt_cmd  <= 1'b0;
                evt_data <= 1'b0;
            end
            if (stop_det) begin
                if (active) begin
                    evt_cmd   <= 1'b1;
                    stat_stop <= 1'b1;
                end
                state   <= ST_IDLE;
                active  <= 1'b0;
                sda_drv <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bitcnt  <= 4'd0;
                sda_drv <= 1'b0;
            end else if (scl_rise) begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    ST_TACK: stat_ack <= ~sda_f;
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_ADDR: if (bitcnt == 4'd8) begin
                        if (addr_hit) begin
                            evt_cmd   <= 1'b1;
                            stat_stop <= 1'b0;
                            stat_rw   <= shreg[0];
                            active    <= 1'b1;
                            sda_drv   <= 1'b1;
                            state     <= ST_AACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                    ST_AACK: begin
                        sda_drv <= 1'b0;
                        bitcnt  <= 4'd0;
                        state   <= stat_rw ? ST_LOAD : ST_RX;
                    end
                    ST_RX: if (bitcnt == 4'd8) begin
                        rx_byte  <= shreg;
                        evt_data <= 1'b1;
                        stat_rw  <= 1'b0;
                        state    <= ST_RACK;
                    end
                    ST_RACK: begin
                        bitcnt <= 4'd0;
                        state  <= ST_RX;
                    end
                    ST_TX: begin
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) begin
                            sda_drv <= 1'b0;
                            state   <= ST_TACK;
                        end else begin
                            shreg   <= {shreg[6:0], 1'b0};
                            sda_drv <= ~shreg[6];
                        end
                    end
                    ST_TACK: begin
                        evt_data <= 1'b1;
                        stat_rw  <= 1'b1;
                        state    <= stat_ack ? ST_LOAD : ST_SKIP;
                    end
                    default: ;
                endcase
            end else if (state == ST_LOAD && !(stall_en && pending)) begin
                shreg   <= tx_hold;
                sda_drv <= ~tx_hold[7];
                bitcnt  <= 4'd0;
                state   <= ST_TX;
            end
        end
    end

    // Begin stretching only once SCL is already low, release on clear
    always_ff @(posedge clk) begin
        if (!rst_n)           hold_q <= 1'b0;
        else if (!stall_want) hold_q <= 1'b0;
        else if (!scl_f)      hold_q <= 1'b1;
    end

    assign scl_oe = hold_q & stall_want;
    assign sda_oe = sda_drv | ((state == ST_RACK) & ack_en);

    // R3: nothing is driven on SDA outside a transaction
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R2: an address event comes with the ACK already on SDA
    a_r2_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_cmd) && !stat_stop) |-> sda_oe);

    // R4: an address event needs a non-zero own address
    a_r4_zero_addr_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_cmd) && !stat_stop) |-> ($past(own_addr[7:1]) != 7'd0));

    // R8: with stall on, a byte event stretches SCL on the next cycle
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_data) && stall_en && !evt_clr && !stop_det) |=> scl_oe);

    // R10: a clear with no new milestone empties both event flags
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !scl_fall && !stop_det) |=> !(evt_cmd || evt_data));

endmodule

// File: rtl/i2c_stall_target.sv
// Top of the software-paced I2C target: line conditioning, command register
// and target engine, plus the interrupt request. Assumes open-drain pads
// outside the block (an oe of 1 pulls the line low).
module i2c_stall_target #(
    parameter int FILT_LEN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic [7:0]  own_addr,
    input  logic        cmd_we,
    input  logic [15:0] cmd_word,
    output logic        evt_cmd,
    output logic        evt_data,
    output logic        stat_stop,
    output logic        stat_rw,
    output logic        stat_ack,
    output logic [7:0]  rx_byte,
    output logic        irq
);
    logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;
    logic stall_en, ack_en, irq_mask, evt_clr;
    logic [7:0] tx_hold;

    i2ct_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_f(scl_f), .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .stall_en(stall_en), .ack_en(ack_en), .irq_mask(irq_mask),
        .tx_hold(tx_hold), .evt_clr(evt_clr)
    );

    i2ct_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .own_addr(own_addr),
        .stall_en(stall_en), .ack_en(ack_en), .tx_hold(tx_hold), .evt_clr(evt_clr),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .evt_cmd(evt_cmd), .evt_data(evt_data),
        .stat_stop(stat_stop), .stat_rw(stat_rw), .stat_ack(stat_ack),
        .rx_byte(rx_byte)
    );

    assign irq = (evt_cmd | evt_data) & ~irq_mask;

    // R9: a masked block never requests an interrupt
    a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);

endmodule

// File: tb/i2c_stall_target_tb_top.sv
module i2c_stall_target_tb_top;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [7:0] own_addr = 8'h58;
    logic cmd_we = 1'b0;
    logic [15:0] cmd_word = 16'h0000;
    logic scl_oe, sda_oe, evt_cmd, evt_data, stat_stop, stat_rw, stat_ack, irq;
    logic [7:0] rx_byte;
    wire scl_line = m_scl & ~scl_oe;
    wire sda_line = m_sda & ~sda_oe;

    int total = 0, bad = 0;
    bit done = 0;
    bit mdl_pend = 0, mdl_stall = 0;

    always #5 clk = ~clk;

    i2c_stall_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .cmd_we(cmd_we), .cmd_word(cmd_word), .evt_cmd(evt_cmd), .evt_data(evt_data),
        .stat_stop(stat_stop), .stat_rw(stat_rw), .stat_ack(stat_ack),
        .rx_byte(rx_byte), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8 per-clock model: SCL may only be pulled while an event is expected and stall is on
    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (scl_oe && !(mdl_pend && mdl_stall)) begin
                bad++;
                $display("FAIL R8 scl_oe actual=1 expected=0 at %0t", $time);
            end
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_cmd(input logic [15:0] v);
        if (v[0]) mdl_stall = 1;
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_word = v;
        @(negedge clk);
        cmd_we = 1'b0;
        if (v[6]) mdl_pend = 0;
        if (!v[0]) mdl_stall = 0;
    endtask

    task automatic m_bit(input logic b, input logic glitch, output logic got);
        m_sda = b;
        wcyc(HALF);
        m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
        wcyc(HALF / 2);
        if (glitch) begin
            m_sda = ~b;
            @(negedge clk);
            m_sda = b;
        end
        got = sda_line;
        wcyc(HALF / 2);
        m_scl = 1'b0;
    endtask

    task automatic m_byte(input logic [7:0] v, input int glitch_bit, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic g;
            m_bit(v[i], (i == glitch_bit), g);
            got[i] = g;
        end
        wcyc(10);
    endtask

    task automatic m_start();
        m_sda = 1'b1;
        m_scl = 1'b1;
        wcyc(HALF);
        m_sda = 1'b0;
        wcyc(HALF);
        m_scl = 1'b0;
    endtask

    task automatic m_stop();
        m_sda = 1'b0;
        wcyc(HALF);
        m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
        wcyc(HALF);
        m_sda = 1'b1;
        wcyc(HALF);
    endtask

    initial begin
        logic [7:0] got;
        logic a;
        wcyc(4);
        rst_n = 1'b1;
        wcyc(2);
        // R1 reset state
        check("R1 evt", {evt_cmd, evt_data}, 0);
        check("R1 status", {stat_stop, stat_rw, stat_ack}, 0);
        check("R1 rx_byte", rx_byte, 0);
        check("R1 drive", {irq, scl_oe, sda_oe}, 0);

        // Matching write, no stall: ack enable on
        sw_cmd(16'h0048);
        m_start();
        mdl_pend = 1;
        m_byte(8'h58, -1, got);
        check("R2 evt_cmd", evt_cmd, 1);
        check("R2 stat_stop", stat_stop, 0);
        check("R2 stat_rw", stat_rw, 0);
        check("R9 irq", irq, 1);
        sw_cmd(16'h0048);
        check("R10 cleared", {evt_cmd, evt_data}, 0);
        m_bit(1'b1, 1'b0, a);
        check("R2 addr ack", a, 0);
        mdl_pend = 1;
        m_byte(8'hA5, -1, got);
        check("R5 evt_data", evt_data, 1);
        check("R5 rx_byte", rx_byte, 8'hA5);
        check("R5 stat_rw", stat_rw, 0);
        sw_cmd(16'h0048);
        m_bit(1'b1, 1'b0, a);
        check("R5 ack on", a, 0);
        // R11 glitch inside bit 3 of this byte
        mdl_pend = 1;
        m_byte(8'h3C, 3, got);
        check("R11 evt_data", evt_data, 1);
        check("R11 rx_byte", rx_byte, 8'h3C);
        sw_cmd(16'h0040);
        m_bit(1'b1, 1'b0, a);
        check("R5 nack", a, 1);
        mdl_pend = 1;
        m_stop();
        wcyc(10);
        check("R7 stop evt", evt_cmd, 1);
        check("R7 stat_stop", stat_stop, 1);
        sw_cmd(16'h0040);

        // R3 non-matching address
        m_start();
        m_byte(8'h22, -1, got);
        check("R3 no evt", {evt_cmd, evt_data}, 0);
        m_bit(1'b1, 1'b0, a);
        check("R3 no ack", a, 1);
        m_stop();
        wcyc(10);
        check("R7 no stop evt", evt_cmd, 0);

        // R4 own address zero
        own_addr = 8'h00;
        m_start();
        m_byte(8'h00, -1, got);
        check("R4 zero byte evt", evt_cmd, 0);
        m_bit(1'b1, 1'b0, a);
        check("R4 zero byte ack", a, 1);
        m_stop();
        m_start();
        m_byte(8'h58, -1, got);
        check("R4 old addr evt", evt_cmd, 0);
        m_bit(1'b1, 1'b0, a);
        check("R4 old addr ack", a, 1);
        m_stop();
        own_addr = 8'h58;

        // Stalled read
        sw_cmd(16'h0041);
        m_start();
        mdl_pend = 1;
        m_byte(8'h59, -1, got);
        check("R2 read evt", evt_cmd, 1);
        check("R2 read rw", stat_rw, 1);
        check("R8 stall addr", scl_oe, 1);
        m_sda = 1'b1;
        m_scl = 1'b1;
        wcyc(30);
        check("R8 line held", scl_line, 0);
        sw_cmd(16'hC341);
        m_bit(1'b1, 1'b0, a);
        check("R2 read ack", a, 0);
        mdl_pend = 1;
        m_byte(8'hFF, -1, got);
        check("R6 byte1", got, 8'hC3);
        m_bit(1'b0, 1'b0, a);
        wcyc(10);
        check("R6 evt_data", evt_data, 1);
        check("R6 stat_ack", stat_ack, 1);
        check("R6 stat_rw", stat_rw, 1);
        check("R8 stall data", scl_oe, 1);
        sw_cmd(16'h5E51);
        mdl_pend = 1;
        m_byte(8'hFF, -1, got);
        check("R6 byte2", got, 8'h5E);
        m_bit(1'b1, 1'b0, a);
        wcyc(10);
        check("R6 nack seen", stat_ack, 0);
        check("R6 evt nack", evt_data, 1);
        check("R9 masked", irq, 0);
        sw_cmd(16'h0041);
        mdl_pend = 1;
        m_stop();
        wcyc(10);
        check("R7 read stop", {evt_cmd, stat_stop}, 3);
        check("R9 unmasked", irq, 1);
        check("R8 no stall idle", scl_oe, 0);
        sw_cmd(16'h0040);
        check("R10 final clear", {evt_cmd, evt_data, irq}, 0);

        wcyc(5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule